// File: doc/BRIEF.md
# Interleaved I/Q Sample Splitter

This block takes one sample bus that carries I and Q converter samples in turn, one sample on each edge of a data clock. It captures the bus on both edges and forms the samples into I/Q pairs. Each pair is presented as two parallel output words that change together. Static configuration inputs set three things: which clock edge carries the I channel, which channel opens a pair, and whether the incoming words are two's complement. Two's-complement words are converted to an offset-binary (unsigned) code before they reach the outputs.

Dual-edge capture uses one register clocked on the rising edge and one clocked on the falling edge. All pairing and output logic runs in the rising-edge domain. A fully captured pair is loaded into the output registers on a rising edge, and a valid strobe is raised for the cycle in which that pair is shown. A capture enable can stop all sampling. Each channel has a clock-off input that holds its output word, and a power-down input holds both words.

Top module: `iq_lane_splitter`

## Requirements
- R1: While reset is asserted, and after it is released until the first pair is loaded, `i_out` and `q_out` are 0 and `pair_valid` is 0.
- R2: With `cfg_i_on_rise`=1 and `cfg_i_first`=1, the word captured on rising edge k becomes `i_out` and the word captured on the next falling edge becomes `q_out`. Both appear after rising edge k+1.
- R3: With `cfg_i_on_rise`=0, the channel mapping swaps: falling-edge words go to `i_out` and rising-edge words go to `q_out`.
- R4: When `cfg_i_first` differs from `cfg_i_on_rise`, a pair opens on a falling edge. The falling-edge word of cycle k-1 and the rising-edge word of cycle k are loaded together after rising edge k+1.
- R5: With `cfg_twos`=1, bit 13 of each output word is the inverse of the captured bit 13, and bits 12:0 pass through unchanged. With `cfg_twos`=0, the word passes through unchanged.
- R6: While `i_clk_off`=1 at a rising edge, `i_out` keeps its value across that edge, and `q_out` still loads.
- R7: While `q_clk_off`=1 at a rising edge, `q_out` keeps its value across that edge, and `i_out` still loads.
- R8: While `power_down`=1 at a rising edge, both output words keep their values and `pair_valid` goes to 0 after that edge.
- R9: An edge seen with `cap_en`=0 captures nothing. A pair containing such an edge is never loaded, and `pair_valid` stays 0 for it. After re-enabling, the first pair loaded is one whose two words were both captured while enabled.
- R10: `pair_valid` is 1 after exactly those rising edges at which a complete pair was loaded with `power_down`=0, and both words of that pair update on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; samples on both edges, outputs on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 14 | Interleaved I/Q sample bus |
| cap_en | input | 1 | Capture enable (1 = sample the bus) |
| cfg_i_on_rise | input | 1 | 1: I on rising edge; 0: I on falling edge |
| cfg_i_first | input | 1 | 1: I opens each pair; 0: Q opens each pair |
| cfg_twos | input | 1 | 1: input is two's complement, convert to offset binary |
| i_clk_off | input | 1 | Hold the I output word |
| q_clk_off | input | 1 | Hold the Q output word |
| power_down | input | 1 | Hold both output words and suppress the valid strobe |
| i_out | output | 14 | I channel sample, unsigned code |
| q_out | output | 14 | Q channel sample, unsigned code |
| pair_valid | output | 1 | High for the cycle in which a newly loaded pair is shown |

## Verification
The data words on the two edges of each cycle are random and distinct, so taking a word from the wrong edge or the wrong cycle shows up as a mismatch. This separates the edge-to-channel mapping from the pair order, including the case where a pair spans two clock cycles. Configuration, clock-off and power-down inputs are re-drawn every cycle, which checks that each channel holds independently and that the format change is applied per load. Directed stretches cover the reset state, the default mode, and gaps in capture enable. For the enable gaps, the bench checks that a pair which straddles the gap is dropped while a pair captured entirely after it is accepted.

// File: rtl/iq_lane_splitter.sv
`timescale 1ns/1ps
module iq_lane_splitter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         cap_en,
  input  logic         cfg_i_on_rise,
  input  logic         cfg_i_first,
  input  logic         cfg_twos,
  input  logic         i_clk_off,
  input  logic         q_clk_off,
  input  logic         power_down,
  output logic [W-1:0] i_out,
  output logic [W-1:0] q_out,
  output logic         pair_valid
);
  localparam logic [W-1:0] MSB_FLIP = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] rise_q, fall_q, fall_d;
  logic         rise_v, fall_v, fall_dv;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= '0;
      fall_v <= 1'b0;
    end else begin
      fall_v <= cap_en;
      if (cap_en) fall_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q  <= '0;
      rise_v  <= 1'b0;
      fall_d  <= '0;
      fall_dv <= 1'b0;
    end else begin
      rise_v  <= cap_en;
      if (cap_en) rise_q <= din;
      fall_d  <= fall_q;
      fall_dv <= fall_v;
    end
  end

  logic         opens_on_rise;
  logic         pair_ok;
  logic         load;
  logic [W-1:0] fall_sel, i_raw, q_raw, flip;

  assign opens_on_rise = ~(cfg_i_first ^ cfg_i_on_rise);
  assign pair_ok  = opens_on_rise ? (rise_v & fall_v) : (fall_dv & rise_v);
  assign fall_sel = opens_on_rise ? fall_q : fall_d;
  assign i_raw    = cfg_i_on_rise ? rise_q : fall_sel;
  assign q_raw    = cfg_i_on_rise ? fall_sel : rise_q;
  assign flip     = cfg_twos ? MSB_FLIP : '0;
  assign load     = pair_ok & ~power_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_out      <= '0;
      q_out      <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= load;
      if (load && !i_clk_off) i_out <= i_raw ^ flip;
      if (load && !q_clk_off) q_out <= q_raw ^ flip;
    end
  end
endmodule

// File: rtl/iq_lane_splitter_chk.sv
`timescale 1ns/1ps
module iq_lane_splitter_chk #(
  parameter int W = 14
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cap_en,
  input logic         i_clk_off,
  input logic         q_clk_off,
  input logic         power_down,
  input logic [W-1:0] i_out,
  input logic [W-1:0] q_out,
  input logic         pair_valid
);
  // R6
  i_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_clk_off |=> $stable(i_out));
  // R7
  q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_clk_off |=> $stable(q_out));
  // R8
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> ($stable(i_out) && $stable(q_out) && !pair_valid));
  // R9
  no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ##1 !pair_valid);
  // R10
  i_update_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(i_out) |-> pair_valid);
  // R10
  q_update_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_out) |-> pair_valid);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (i_out == '0 && q_out == '0 && !pair_valid));
endmodule

bind iq_lane_splitter iq_lane_splitter_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .i_clk_off(i_clk_off),
  .q_clk_off(q_clk_off), .power_down(power_down), .i_out(i_out),
  .q_out(q_out), .pair_valid(pair_valid));

// File: tb/iq_lane_splitter_tb_top.sv
`timescale 1ns/1ps
module iq_lane_splitter_tb_top;
  localparam int W = 14;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] din = '0;
  logic cap_en = 1'b1, cfg_i_on_rise = 1'b1, cfg_i_first = 1'b1, cfg_twos = 1'b0;
  logic i_clk_off = 1'b0, q_clk_off = 1'b0, power_down = 1'b0;
  logic [W-1:0] i_out, q_out;
  logic pair_valid;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string tag_force = "";

  logic [W-1:0] h_r = '0, h_f = '0, h_f2 = '0;
  bit h_en = 1'b0, h_en2 = 1'b0;
  logic [W-1:0] exp_i = '0, exp_q = '0;
  bit exp_v = 1'b0;

  always #2.5 clk = ~clk;

  iq_lane_splitter #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .cap_en(cap_en),
    .cfg_i_on_rise(cfg_i_on_rise), .cfg_i_first(cfg_i_first), .cfg_twos(cfg_twos),
    .i_clk_off(i_clk_off), .q_clk_off(q_clk_off), .power_down(power_down),
    .i_out(i_out), .q_out(q_out), .pair_valid(pair_valid));

  function automatic logic [W-1:0] to_unsigned(logic [W-1:0] x, bit twos);
    return twos ? {~x[W-1], x[W-2:0]} : x;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string cfg_tag();
    if (tag_force != "") return tag_force;
    if (cfg_twos) return "R5";
    if (cfg_i_first != cfg_i_on_rise) return "R4";
    if (!cfg_i_on_rise) return "R3";
    return "R2";
  endfunction

  task automatic step(logic [W-1:0] rv, logic [W-1:0] fv, bit en, bit pd,
                      bit ioff, bit qoff, bit irise, bit ifirst, bit twos);
    bit opens_rise, ok;
    logic [W-1:0] rs, fs, ei, eq;
    @(negedge clk); #1;
    din = rv; cap_en = en; power_down = pd; i_clk_off = ioff; q_clk_off = qoff;
    cfg_i_on_rise = irise; cfg_i_first = ifirst; cfg_twos = twos;
    @(posedge clk); #1;
    opens_rise = (ifirst == irise);
    ok = opens_rise ? h_en : (h_en && h_en2);
    rs = h_r;
    fs = opens_rise ? h_f : h_f2;
    ei = irise ? rs : fs;
    eq = irise ? fs : rs;
    exp_v = ok && !pd;
    if (exp_v && !ioff) exp_i = to_unsigned(ei, twos);
    if (exp_v && !qoff) exp_q = to_unsigned(eq, twos);
    chk(ioff ? "R6" : (pd ? "R8" : cfg_tag()), i_out, exp_i);
    chk(qoff ? "R7" : (pd ? "R8" : cfg_tag()), q_out, exp_q);
    chk((tag_force != "") ? tag_force : "R10", {{(W-1){1'b0}}, pair_valid},
        {{(W-1){1'b0}}, exp_v});
    din = fv;
    h_f2 = h_f; h_en2 = h_en; h_r = rv; h_f = fv; h_en = en;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", i_out, '0);
    chk("R1", q_out, '0);
    chk("R1", {{(W-1){1'b0}}, pair_valid}, '0);
    @(negedge clk); #1;
    cap_en = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", {{(W-1){1'b0}}, pair_valid}, '0);

    // R2 default mode, directed values
    for (int k = 0; k < 6; k++)
      step(14'h0100 + W'(k), 14'h2200 + W'(k), 1, 0, 0, 0, 1, 1, 0);
    // R3, R4 directed orderings
    for (int k = 0; k < 5; k++)
      step(14'h0A00 + W'(k), 14'h3500 + W'(k), 1, 0, 0, 0, 0, 1, 0);
    for (int k = 0; k < 5; k++)
      step(14'h0B00 + W'(k), 14'h1C00 + W'(k), 1, 0, 0, 0, 1, 0, 0);
    for (int k = 0; k < 5; k++)
      step(14'h0C00 + W'(k), 14'h1D00 + W'(k), 1, 0, 0, 0, 0, 0, 0);
    // R5 extremes of two's complement
    step(14'h2000, 14'h1FFF, 1, 0, 0, 0, 1, 1, 1);
    step(14'h3FFF, 14'h0000, 1, 0, 0, 0, 1, 1, 1);
    step(14'h0001, 14'h2001, 1, 0, 0, 0, 1, 1, 1);

    // R9 enable gaps in both pair orders
    tag_force = "R9";
    for (int m = 0; m < 2; m++) begin
      step(14'h0111, 14'h0222, 1, 0, 0, 0, 1, m[0] ? 1'b0 : 1'b1, 0);
      step(14'h0333, 14'h0444, 0, 0, 0, 0, 1, m[0] ? 1'b0 : 1'b1, 0);
      step(14'h0555, 14'h0666, 0, 0, 0, 0, 1, m[0] ? 1'b0 : 1'b1, 0);
      step(14'h0777, 14'h0888, 1, 0, 0, 0, 1, m[0] ? 1'b0 : 1'b1, 0);
      step(14'h0999, 14'h0AAA, 1, 0, 0, 0, 1, m[0] ? 1'b0 : 1'b1, 0);
      step(14'h0BBB, 14'h0CCC, 1, 0, 0, 0, 1, m[0] ? 1'b0 : 1'b1, 0);
    end
    tag_force = "";

    // R6 R7 R8 directed holds
    step(14'h1234, 14'h2345, 1, 0, 1, 0, 1, 1, 0);
    step(14'h3456, 14'h0567, 1, 0, 0, 1, 1, 1, 0);
    step(14'h1678, 14'h2789, 1, 1, 0, 0, 1, 1, 0);
    step(14'h189A, 14'h29AB, 1, 0, 0, 0, 1, 1, 0);

    void'($urandom(32'd2024));
    for (int n = 0; n < 600; n++) begin
      step(W'($urandom), W'($urandom), ($urandom % 10) != 0,
           ($urandom % 8) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
           ($urandom % 2) == 1, ($urandom % 2) == 1, ($urandom % 2) == 1);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule